// File: doc/BRIEF.md
# Banked Memory Port Controller

This block holds the 8-bit memory-control port of an 8-bit home system and turns it, together with the 16-bit address of the current bus access, into chip selects for the whole memory map. The processor writes the port at address $D301 and can read it back. The port value decides three things. It sets which system ROMs (operating system, BASIC, self-test) are visible. It sets whether the 16K window at $4000–$7FFF shows base RAM or an extended RAM bank. It sets which extended bank is shown.

Both the processor and the video fetch engine use the window. An input strobe tells the block which of the two owns the current access, and the block applies that agent's access-control bit. The expansion layout is fixed at build time by a parameter: 4 banks, 8 banks, 16 banks (bit 7 shared with self-test), or 64 banks (one access bit shared by both agents, with bits 1 and 7 used as bank bits). The same port bits mean different things in each layout. The decode is combinational from the registered port value, so chip selects and the extended address follow the bus address in the same cycle.

Each access falls into one of six named decode classes: low RAM, window, mid RAM, BASIC area, OS area and I/O hole. Every class maps to exactly one chip select, except the I/O hole, which maps to none.

Top module: `pm_banked_port`

## Requirements
- R1: After reset the port holds $FF. This means OS ROM on, BASIC off, self-test off and base RAM in the window for both agents.
- R2: A write strobe with address $D301 loads the write data into the port at the next clock edge. Writes to any other address, or address $D301 without the strobe, leave the port unchanged. The readback output always shows the port value, and the hit output is high exactly when the address is $D301.
- R3: In $C000–$CFFF and $D800–$FFFF, the OS ROM select is active when port bit 0 is 1. Otherwise the base RAM select is active.
- R4: In $D000–$D7FF no chip select is active.
- R5: In $A000–$BFFF, the BASIC ROM select is active when port bit 1 is 0. Otherwise base RAM is selected (see R10 for the 64-bank layout).
- R6: In the 4- and 8-bank layouts, port bit 7 = 0 selects the self-test ROM in $5000–$57FF. This takes priority over the window's RAM choice for both agents.
- R7: In the 4-, 8- and 16-bank layouts, a processor access in $4000–$7FFF selects extended RAM when bit 4 is 0 and base RAM when bit 4 is 1. A video access (strobe high) uses bit 5 the same way.
- R8: On an extended RAM access, the extended address is {bank, addr[13:0]}. The bank is, MSB first: {b3,b2} in the 4-bank layout; {b6,b3,b2} in the 8-bank layout; {b7,b6,b3,b2} in the 16-bank layout; and {b1,b7,b6,b5,b3,b2} in the 64-bank layout.
- R9: In the 16-bank layout, bit 7 = 0 selects the self-test ROM in $5000–$57FF only when bits 4 and 5 are both 1.
- R10: In the 64-bank layout, bit 4 alone selects extended RAM (0) or base RAM (1) for both agents. The BASIC ROM (bit 1 = 0) and the self-test ROM (bit 7 = 0) appear only while bit 4 is 1.
- R11: Every address outside the I/O hole activates exactly one chip select. Addresses in $0000–$3FFF and $8000–$9FFF always select base RAM.
- R12: Chip selects and the extended address are combinational in the bus address and the access strobe. They are valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Bus address of the current access |
| cpu_wdata | input | 8 | Write data for the port |
| cpu_wr | input | 1 | Write strobe |
| vid_fetch | input | 1 | 1 = the access belongs to the video fetch engine |
| port_rdata | output | 8 | Port readback |
| port_hit | output | 1 | Address equals the port address |
| os_rom_cs | output | 1 | OS ROM select |
| basic_rom_cs | output | 1 | BASIC ROM select |
| selftest_rom_cs | output | 1 | Self-test ROM select |
| base_ram_cs | output | 1 | Base RAM select |
| ext_ram_cs | output | 1 | Extended RAM select |
| ext_addr | output | bank bits + 14 | Extended RAM physical address |

## Verification
The assertions check on every cycle that the port loads only on a strobed write to its own address and otherwise holds. They also check that at most one select is active, that the I/O hole selects nothing while every other address selects exactly one target, and that an extended access carries the window offset in the low address bits. What a given port value means in each layout cannot be seen cycle by cycle. This covers the bank numbering, the per-agent access bit, the self-test conditions tied to bits 4 and 5, and the BASIC and self-test gating in the 64-bank layout. Only the bench's sweep of all 256 port values over every address class, for both agents and all four layouts, shows those.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        LAY_X4  = 2'd0,
        LAY_X8  = 2'd1,
        LAY_X16 = 2'd2,
        LAY_X64 = 2'd3
    } layout_e;

    typedef enum logic [2:0] {
        RG_LOWRAM,
        RG_WINDOW,
        RG_MIDRAM,
        RG_BASIC,
        RG_OS,
        RG_IOHOLE
    } region_e;

    typedef struct packed {
        logic os;
        logic basic;
        logic selftest;
        logic base;
        logic ext;
    } sel_t;

    function automatic int unsigned bank_bits(layout_e l);
        case (l)
            LAY_X4:  return 2;
            LAY_X8:  return 3;
            LAY_X16: return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/pm_port_reg.sv
module pm_port_reg #(
    parameter logic [15:0] PORT_ADDR = 16'hD301,
    parameter logic [7:0]  RESET_VAL = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        wr,
    output logic [7:0]  q,
    output logic        hit
);

    assign hit = (addr == PORT_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (wr && hit) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/pm_region_dec.sv
module pm_region_dec import pm_pkg::*; (
    input  logic [15:0] addr,
    output region_e     region,
    output logic        in_selftest
);

    always_comb begin
        if (addr[15:14] == 2'b00) begin
            region = RG_LOWRAM;
        end else if (addr[15:14] == 2'b01) begin
            region = RG_WINDOW;
        end else if (addr[15:13] == 3'b100) begin
            region = RG_MIDRAM;
        end else if (addr[15:13] == 3'b101) begin
            region = RG_BASIC;
        end else if (addr[15:11] == 5'b11010) begin
            region = RG_IOHOLE;
        end else begin
            region = RG_OS;
        end
    end

    assign in_selftest = (addr[15:11] == 5'b01010);

endmodule

// File: rtl/pm_layout_ctl.sv
module pm_layout_ctl import pm_pkg::*; #(
    parameter layout_e LAYOUT = LAY_X16,
    localparam int unsigned BANK_W = bank_bits(LAYOUT)
) (
    input  logic [7:0]        port,
    output logic              os_on,
    output logic              basic_on,
    output logic              st_on,
    output logic              cpu_ext,
    output logic              vid_ext,
    output logic [BANK_W-1:0] bank
);

    assign os_on = port[0];

    generate
        if (LAYOUT == LAY_X4) begin : g_x4
            wire unused_bits = ^{port[6], port[0]};
            assign bank     = {port[3], port[2]};
            assign basic_on = ~port[1];
            assign st_on    = ~port[7];
            assign cpu_ext  = ~port[4];
            assign vid_ext  = ~port[5];
        end else if (LAYOUT == LAY_X8) begin : g_x8
            wire unused_bits = port[0];
            assign bank     = {port[6], port[3], port[2]};
            assign basic_on = ~port[1];
            assign st_on    = ~port[7];
            assign cpu_ext  = ~port[4];
            assign vid_ext  = ~port[5];
        end else if (LAYOUT == LAY_X16) begin : g_x16
            wire unused_bits = port[0];
            assign bank     = {port[7], port[6], port[3], port[2]};
            assign basic_on = ~port[1];
            assign st_on    = ~port[7] & port[4] & port[5];
            assign cpu_ext  = ~port[4];
            assign vid_ext  = ~port[5];
        end else begin : g_x64
            wire unused_bits = port[0];
            assign bank     = {port[1], port[7], port[6], port[5], port[3], port[2]};
            assign basic_on = ~port[1] & port[4];
            assign st_on    = ~port[7] & port[4];
            assign cpu_ext  = ~port[4];
            assign vid_ext  = ~port[4];
        end
    endgenerate

endmodule

// File: rtl/pm_banked_port.sv
module pm_banked_port import pm_pkg::*; #(
    parameter layout_e     LAYOUT    = LAY_X16,
    parameter logic [15:0] PORT_ADDR = 16'hD301,
    parameter logic [7:0]  RESET_VAL = 8'hFF,
    localparam int unsigned BANK_W   = bank_bits(LAYOUT),
    localparam int unsigned EXT_AW   = BANK_W + 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              vid_fetch,
    output logic [7:0]        port_rdata,
    output logic              port_hit,
    output logic              os_rom_cs,
    output logic              basic_rom_cs,
    output logic              selftest_rom_cs,
    output logic              base_ram_cs,
    output logic              ext_ram_cs,
    output logic [EXT_AW-1:0] ext_addr
);

    logic [7:0]        port_q;
    region_e           region;
    logic              in_st;
    logic              os_on, basic_on, st_on, cpu_ext, vid_ext;
    logic [BANK_W-1:0] bank;
    logic              win_ext;
    sel_t              sel;

    pm_port_reg #(
        .PORT_ADDR(PORT_ADDR),
        .RESET_VAL(RESET_VAL)
    ) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (cpu_addr),
        .wdata(cpu_wdata),
        .wr   (cpu_wr),
        .q    (port_q),
        .hit  (port_hit)
    );

    pm_region_dec u_region (
        .addr       (cpu_addr),
        .region     (region),
        .in_selftest(in_st)
    );

    pm_layout_ctl #(
        .LAYOUT(LAYOUT)
    ) u_layout (
        .port    (port_q),
        .os_on   (os_on),
        .basic_on(basic_on),
        .st_on   (st_on),
        .cpu_ext (cpu_ext),
        .vid_ext (vid_ext),
        .bank    (bank)
    );

    assign win_ext = vid_fetch ? vid_ext : cpu_ext;

    always_comb begin
        sel = '0;
        unique case (region)
            RG_IOHOLE: sel = '0;
            RG_OS:     if (os_on) sel.os = 1'b1; else sel.base = 1'b1;
            RG_BASIC:  if (basic_on) sel.basic = 1'b1; else sel.base = 1'b1;
            RG_WINDOW: begin
                if (st_on && in_st)  sel.selftest = 1'b1;
                else if (win_ext)    sel.ext      = 1'b1;
                else                 sel.base     = 1'b1;
            end
            RG_LOWRAM, RG_MIDRAM: sel.base = 1'b1;
            default:   sel = '0;
        endcase
    end

    assign port_rdata      = port_q;
    assign os_rom_cs       = sel.os;
    assign basic_rom_cs    = sel.basic;
    assign selftest_rom_cs = sel.selftest;
    assign base_ram_cs     = sel.base;
    assign ext_ram_cs      = sel.ext;
    assign ext_addr        = {bank, cpu_addr[13:0]};

endmodule

// File: rtl/pm_banked_port_chk.sv
module pm_banked_port_chk #(
    parameter logic [15:0] PORT_ADDR = 16'hD301,
    parameter int unsigned EXT_AW    = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_wr,
    input logic [7:0]        port_rdata,
    input logic              os_rom_cs,
    input logic              basic_rom_cs,
    input logic              selftest_rom_cs,
    input logic              base_ram_cs,
    input logic              ext_ram_cs,
    input logic [EXT_AW-1:0] ext_addr
);

    logic [4:0] cs_all;
    logic       io_hole;
    assign cs_all  = {os_rom_cs, basic_rom_cs, selftest_rom_cs, base_ram_cs, ext_ram_cs};
    assign io_hole = (cpu_addr >= 16'hD000) && (cpu_addr <= 16'hD7FF);

    a_r2_port_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == PORT_ADDR) |=> port_rdata == $past(cpu_wdata));

    a_r2_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == PORT_ADDR) |=> $stable(port_rdata));

    a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_all));

    a_r11_covered: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hole |-> $countones(cs_all) == 1);

    a_r4_io_hole: assert property (@(posedge clk) disable iff (!rst_n)
        io_hole |-> cs_all == 5'b0);

    a_r8_ext_offset: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ram_cs |-> (cpu_addr[15:14] == 2'b01 && ext_addr[13:0] == cpu_addr[13:0]));

endmodule

bind pm_banked_port pm_banked_port_chk #(
    .PORT_ADDR(PORT_ADDR),
    .EXT_AW   (EXT_AW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_addr       (cpu_addr),
    .cpu_wdata      (cpu_wdata),
    .cpu_wr         (cpu_wr),
    .port_rdata     (port_rdata),
    .os_rom_cs      (os_rom_cs),
    .basic_rom_cs   (basic_rom_cs),
    .selftest_rom_cs(selftest_rom_cs),
    .base_ram_cs    (base_ram_cs),
    .ext_ram_cs     (ext_ram_cs),
    .ext_addr       (ext_addr)
);

// File: tb/sim_pm_banked_port.sv
module sim_pm_banked_port;
    import pm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic        vid_fetch = 1'b0;

    logic [7:0]  rd_o  [4];
    logic        hit_o [4];
    logic [4:0]  cs_o  [4];
    logic [19:0] xa_o  [4];

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    for (genvar g = 0; g < 4; g++) begin : g_lay
        localparam layout_e L = layout_e'(g);
        localparam int unsigned AW = bank_bits(L) + 14;
        logic [AW-1:0] xa;
        logic os, ba, st, bs, ex;
        pm_banked_port #(.LAYOUT(L)) u0 (
            .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
            .cpu_wr(cpu_wr), .vid_fetch(vid_fetch), .port_rdata(rd_o[g]),
            .port_hit(hit_o[g]), .os_rom_cs(os), .basic_rom_cs(ba),
            .selftest_rom_cs(st), .base_ram_cs(bs), .ext_ram_cs(ex), .ext_addr(xa)
        );
        assign cs_o[g] = {os, ba, st, bs, ex};
        assign xa_o[g] = 20'(xa);
    end

    // Expected select, bit order {os, basic, selftest, base, ext}
    function automatic logic [4:0] exp_sel(int lay, logic [7:0] p, logic [15:0] a, logic v);
        logic bas_on, st_on, ext_on;
        bas_on = !p[1] && !(lay == 3 && !p[4]);
        if (lay <= 1)       st_on = !p[7];
        else if (lay == 2)  st_on = !p[7] && p[4] && p[5];
        else                st_on = !p[7] && p[4];
        if (lay == 3) ext_on = !p[4];
        else          ext_on = v ? !p[5] : !p[4];
        if (a >= 16'hD000 && a <= 16'hD7FF) return 5'b00000;
        if (a >= 16'hC000) return p[0] ? 5'b10000 : 5'b00010;
        if (a >= 16'hA000) return bas_on ? 5'b01000 : 5'b00010;
        if (a >= 16'h4000 && a <= 16'h7FFF) begin
            if (st_on && a >= 16'h5000 && a <= 16'h57FF) return 5'b00100;
            return ext_on ? 5'b00001 : 5'b00010;
        end
        return 5'b00010;
    endfunction

    function automatic logic [5:0] exp_bank(int lay, logic [7:0] p);
        case (lay)
            0: return {4'b0, p[3], p[2]};
            1: return {3'b0, p[6], p[3], p[2]};
            2: return {2'b0, p[7], p[6], p[3], p[2]};
            default: return {p[1], p[7], p[6], p[5], p[3], p[2]};
        endcase
    endfunction

    function automatic string req_tag(int lay, logic [15:0] a, logic [4:0] e);
        if (a >= 16'hD000 && a <= 16'hD7FF) return "R4";
        if (a >= 16'hC000) return "R3";
        if (a >= 16'hA000) return (lay == 3) ? "R10" : "R5";
        if (a >= 16'h4000 && a <= 16'h7FFF) begin
            if (lay == 3) return "R10";
            if (a >= 16'h5000 && a <= 16'h57FF) return (lay == 2) ? "R9" : "R6";
            return e[0] ? "R8" : "R7";
        end
        return "R11";
    endfunction

    task automatic port_write(logic [15:0] a, logic [7:0] d, logic strobe);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = strobe;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic check_port(logic [7:0] expv, string tag);
        for (int g = 0; g < 4; g++) begin
            checks++;
            if (rd_o[g] !== expv) begin
                errors++;
                $display("FAIL %s layout %0d port readback actual=%h expected=%h", tag, g, rd_o[g], expv);
            end
        end
    endtask

    // R12: outputs are sampled 1 ns after the address changes, with no clock edge between
    task automatic probe(logic [7:0] p, logic [15:0] a, logic v);
        logic [4:0]  e;
        logic [19:0] ex;
        cpu_addr = a; vid_fetch = v;
        #1;
        for (int g = 0; g < 4; g++) begin
            e = exp_sel(g, p, a, v);
            ex = {exp_bank(g, p), 14'b0} | {6'b0, a[13:0]};
            checks++;
            if (cs_o[g] !== e || (e[0] && xa_o[g] !== ex) || hit_o[g] !== (a == 16'hD301)) begin
                errors++;
                $display("FAIL %s layout %0d port=%h addr=%h vid=%0d actual cs=%b xa=%h hit=%b expected cs=%b xa=%h hit=%b",
                         req_tag(g, a, e), g, p, a, v, cs_o[g], xa_o[g], hit_o[g], e, ex, (a == 16'hD301));
            end
        end
    endtask

    localparam int NADDR = 21;
    logic [15:0] alist [NADDR] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h4FFF, 16'h5000,
                                   16'h5400, 16'h57FF, 16'h5800, 16'h6ABC, 16'h7FFF,
                                   16'h8000, 16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000,
                                   16'hCFFF, 16'hD000, 16'hD301, 16'hD7FF, 16'hD800,
                                   16'hFFFF};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset value, and its memory map
        check_port(8'hFF, "R1");
        for (int i = 0; i < NADDR; i++) begin
            probe(8'hFF, alist[i], 1'b0);
            probe(8'hFF, alist[i], 1'b1);
        end

        // R2: writes to other addresses and unstrobed writes are ignored
        port_write(16'hD300, 8'h00, 1'b1);
        #2 check_port(8'hFF, "R2");
        port_write(16'hD301, 8'h00, 1'b0);
        #2 check_port(8'hFF, "R2");
        port_write(16'hD301, 8'h5A, 1'b1);
        #2 check_port(8'h5A, "R2");

        // Sweep of every port value over every address class and agent
        for (int pv = 0; pv < 256; pv++) begin
            port_write(16'hD301, 8'(pv), 1'b1);
            #2 check_port(8'(pv), "R2");
            for (int i = 0; i < NADDR; i++) begin
                probe(8'(pv), alist[i], 1'b0);
                probe(8'(pv), alist[i], 1'b1);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule